// File: doc/BRIEF.md
# Strap-Selected Flash Target Decoder with Register Space

This block sits behind the memory-cycle front end of a flash target that shares a bus with up to fifteen identical siblings. Every cycle arrives as a 32-bit address, a write flag and a one-cycle valid strobe. The block compares a four-bit select field in the address with the board strap of this part and reports in the same cycle whether the part owns the cycle. The front end uses this to decide whether to answer at all. The boot part carries strap 0, and each further part carries the next strap value up. The select field holds the bitwise complement of the strap, so the boot part answers to select field 4'b1111.

Owned cycles with address bit 22 low fall into register space. Register reads return a byte one cycle later. Offset 8'h00 holds a manufacturer code and offset 8'h01 holds a device code; both are parameters. Offset 8'h80 reads the synchronised general-purpose input pins. All other offsets read zero. When the internal-write busy flag is high, a register read returns a status byte instead of register data, and a register write is dropped. When the busy flag is low, a register write is acknowledged. Owned cycles with bit 22 high are array cycles, and this block gives them no response.

A small response state machine drives the outputs. Its states are ST_IDLE (no response), ST_READ (register byte on the read bus), ST_POLL (status byte on the read bus) and ST_WACK (write acknowledged). Every state takes the same transitions on each clock:
- An owned register read while not busy goes to ST_READ.
- An owned register read while busy goes to ST_POLL.
- An owned register write while not busy goes to ST_WACK.
- Anything else goes to ST_IDLE. This covers an owned write while busy, an array cycle, a cycle the part does not own, and a clock with no valid cycle.

Top module: `flash_devsel_regs`

## Requirements
- R1: `claim` is high in the same cycle as `cyc_valid` exactly when `cyc_addr[21:18]` equals the bitwise complement of `strap_id`; `claim` is low whenever `cyc_valid` is low.
- R2: When the select field does not match, `rd_valid` and `wr_accept` stay low in the cycle that follows.
- R3: An owned register read (`cyc_addr[22]`=0, `cyc_write`=0) raises `rd_valid` for exactly one cycle, on the clock after the request, with the byte on `rd_data`; `rd_valid` and `wr_accept` are never high together.
- R4: A read at offset `cyc_addr[7:0]`=8'h80 returns {3'b000, GPI levels}; the pins pass through two flops first, so a pin change is seen only by a read captured on the third clock edge after the change.
- R5: Offset 8'h00 reads the manufacturer parameter (default 8'hA5), and offset 8'h01 reads the device parameter (default 8'h3C).
- R6: Any other register offset reads 8'h00.
- R7: A register read while `wr_busy` is high returns {~`poll_bit7`, toggle, 6'b000000} in place of register data.
- R8: The toggle bit is 0 after reset and inverts after each busy register read. It does not change on non-busy reads, writes or idle cycles.
- R9: An owned register write with `wr_busy` low raises `wr_accept` for one cycle on the next clock; with `wr_busy` high it is dropped, and no `wr_accept` or `rd_valid` follows.
- R10: An owned cycle with `cyc_addr[22]`=1 raises `claim` but produces no `rd_valid` or `wr_accept`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_valid | input | 1 | One-cycle strobe marking a decoded cycle |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_addr | input | 32 | Cycle address |
| strap_id | input | 4 | Board strap identifying this part |
| gpi_pins | input | 5 | Asynchronous general-purpose input pins |
| wr_busy | input | 1 | Internal array write in progress |
| poll_bit7 | input | 1 | Bit 7 of the byte being written internally |
| claim | output | 1 | Same-cycle ownership of the cycle |
| rd_valid | output | 1 | Register read byte valid |
| rd_data | output | 8 | Register read byte |
| wr_accept | output | 1 | Register write accepted |

## Verification
The select match is tried with several straps. Each is paired with the complemented field it must accept and with the plain, uncomplemented field it must refuse, which separates a correct inversion from a missing one. Reads cover every implemented offset and one unimplemented offset, with distinct GPI patterns, so that a wrong mux leg or a leaked reserved bit is visible. The busy tests alternate the poll reference bit across a run of status reads and mix in dropped writes and non-busy reads. This shows that the toggle moves only on busy reads and that the complement is taken live. A back-to-back read sequence on a pin step pins down the two-flop latency of the GPI path.

// File: rtl/flash_sel_pkg.sv
package flash_sel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_POLL = 2'd2,
        ST_WACK = 2'd3
    } resp_state_t;
endpackage

// File: rtl/fsel_sync.sv
module fsel_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_async;
            s2_q <= s1_q;
        end
    end

    assign d_sync = s2_q;
endmodule

// File: rtl/fsel_id_match.sv
module fsel_id_match #(
    parameter int ID_W    = 4,
    parameter int SEL_LSB = 18,
    parameter int ADDR_W  = 32
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ID_W-1:0]   strap,
    output logic              hit
);
    logic [ID_W-1:0] field;
    assign field = addr[SEL_LSB +: ID_W];
    // the select field carries the complemented strap
    assign hit = valid && (field == ~strap);
endmodule

// File: rtl/fsel_reg_mux.sv
module fsel_reg_mux #(
    parameter int       OFF_W   = 8,
    parameter int       GPI_W   = 5,
    parameter logic [7:0] MFR_CODE = 8'hA5,
    parameter logic [7:0] DEV_CODE = 8'h3C,
    parameter logic [OFF_W-1:0] OFF_MFR = 'h00,
    parameter logic [OFF_W-1:0] OFF_DEV = 'h01,
    parameter logic [OFF_W-1:0] OFF_GPI = 'h80
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [GPI_W-1:0] gpi,
    output logic [7:0]       byte_out
);
    localparam int PAD_W = 8 - GPI_W;

    always_comb begin
        byte_out = 8'h00;
        if (offset == OFF_MFR)      byte_out = MFR_CODE;
        else if (offset == OFF_DEV) byte_out = DEV_CODE;
        else if (offset == OFF_GPI) byte_out = {{PAD_W{1'b0}}, gpi};
    end
endmodule

// File: rtl/flash_devsel_regs.sv
module flash_devsel_regs
    import flash_sel_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ID_W      = 4,
    parameter int SEL_LSB   = 18,
    parameter int SPACE_BIT = 22,
    parameter int OFF_W     = 8,
    parameter int GPI_W     = 5,
    parameter logic [7:0] MFR_CODE = 8'hA5,
    parameter logic [7:0] DEV_CODE = 8'h3C,
    parameter logic [OFF_W-1:0] OFF_MFR = 'h00,
    parameter logic [OFF_W-1:0] OFF_DEV = 'h01,
    parameter logic [OFF_W-1:0] OFF_GPI = 'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic              cyc_write,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [ID_W-1:0]   strap_id,
    input  logic [GPI_W-1:0]  gpi_pins,
    input  logic              wr_busy,
    input  logic              poll_bit7,
    output logic              claim,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              wr_accept
);
    logic [GPI_W-1:0] gpi_s;
    logic [7:0]       reg_byte;
    logic             is_reg;
    resp_state_t      state_q, state_d, decided;
    logic             toggle_q;
    logic [7:0]       rd_data_q;

    fsel_sync #(.W(GPI_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(gpi_pins), .d_sync(gpi_s)
    );

    fsel_id_match #(.ID_W(ID_W), .SEL_LSB(SEL_LSB), .ADDR_W(ADDR_W)) u_match (
        .valid(cyc_valid), .addr(cyc_addr), .strap(strap_id), .hit(claim)
    );

    fsel_reg_mux #(
        .OFF_W(OFF_W), .GPI_W(GPI_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE),
        .OFF_MFR(OFF_MFR), .OFF_DEV(OFF_DEV), .OFF_GPI(OFF_GPI)
    ) u_mux (
        .offset(cyc_addr[OFF_W-1:0]), .gpi(gpi_s), .byte_out(reg_byte)
    );

    assign is_reg = claim && !cyc_addr[SPACE_BIT];

    // decision shared by every state: each response lasts one cycle
    always_comb begin
        decided = ST_IDLE;
        if (is_reg) begin
            if (!cyc_write) decided = wr_busy ? ST_POLL : ST_READ;
            else            decided = wr_busy ? ST_IDLE : ST_WACK;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = decided;
            ST_READ: state_d = decided;
            ST_POLL: state_d = decided;
            ST_WACK: state_d = decided;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output process: read byte and status toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= 8'h00;
            toggle_q  <= 1'b0;
        end else begin
            unique case (state_d)
                ST_READ: rd_data_q <= reg_byte;
                ST_POLL: begin
                    rd_data_q <= {~poll_bit7, toggle_q, 6'b000000};
                    toggle_q  <= ~toggle_q;
                end
                ST_IDLE: rd_data_q <= 8'h00;
                ST_WACK: rd_data_q <= 8'h00;
            endcase
        end
    end

    assign rd_valid  = (state_q == ST_READ) || (state_q == ST_POLL);
    assign wr_accept = (state_q == ST_WACK);
    assign rd_data   = rd_data_q;
endmodule

// File: rtl/fsel_checker.sv
module fsel_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cyc_valid,
    input logic        space_bit,
    input logic        wr_busy,
    input logic        claim,
    input logic        rd_valid,
    input logic [7:0]  rd_data,
    input logic        wr_accept
);
    p_claim_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> cyc_valid);

    p_resp_after_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_accept) |-> $past(claim));

    p_single_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_accept));

    p_status_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(wr_busy)) |-> (rd_data[5:0] == 6'd0));

    p_no_wack_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> !$past(wr_busy));

    p_array_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && space_bit) |=> (!rd_valid && !wr_accept));
endmodule

bind flash_devsel_regs fsel_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .space_bit(cyc_addr[22]),
    .wr_busy(wr_busy), .claim(claim), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_accept(wr_accept)
);

// File: tb/sim_flash_devsel_regs.sv
module sim_flash_devsel_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0;
    logic        cyc_write = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic [3:0]  strap_id = '0;
    logic [4:0]  gpi_pins = '0;
    logic        wr_busy = 1'b0;
    logic        poll_bit7 = 1'b0;
    logic        claim, rd_valid, wr_accept;
    logic [7:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_devsel_regs u0 (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
        .cyc_addr(cyc_addr), .strap_id(strap_id), .gpi_pins(gpi_pins),
        .wr_busy(wr_busy), .poll_bit7(poll_bit7), .claim(claim),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_accept(wr_accept)
    );

    typedef struct packed {
        logic [3:0] strap;
        logic       arr;
        logic [3:0] sel;
        logic [7:0] off;
        logic       wr;
        logic [4:0] gpi;
        logic       e_claim;
        logic       e_rv;
        logic [7:0] e_data;
        logic       e_wa;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{4'h0, 1'b0, 4'hF, 8'h00, 1'b0, 5'h00, 1'b1, 1'b1, 8'hA5, 1'b0}, // R5 mfr
        '{4'h0, 1'b0, 4'hF, 8'h01, 1'b0, 5'h00, 1'b1, 1'b1, 8'h3C, 1'b0}, // R5 dev
        '{4'h0, 1'b0, 4'hF, 8'h80, 1'b0, 5'h15, 1'b1, 1'b1, 8'h15, 1'b0}, // R4
        '{4'h0, 1'b0, 4'hF, 8'h80, 1'b0, 5'h0A, 1'b1, 1'b1, 8'h0A, 1'b0}, // R4
        '{4'h0, 1'b0, 4'hF, 8'h42, 1'b0, 5'h1F, 1'b1, 1'b1, 8'h00, 1'b0}, // R6
        '{4'h0, 1'b0, 4'hE, 8'h00, 1'b0, 5'h00, 1'b0, 1'b0, 8'h00, 1'b0}, // R2
        '{4'h5, 1'b0, 4'hA, 8'h80, 1'b0, 5'h1F, 1'b1, 1'b1, 8'h1F, 1'b0}, // R1
        '{4'h5, 1'b0, 4'h5, 8'h80, 1'b0, 5'h1F, 1'b0, 1'b0, 8'h00, 1'b0}, // R2
        '{4'h0, 1'b1, 4'hF, 8'h00, 1'b0, 5'h00, 1'b1, 1'b0, 8'h00, 1'b0}, // R10
        '{4'h0, 1'b0, 4'hF, 8'h80, 1'b1, 5'h00, 1'b1, 1'b0, 8'h00, 1'b1}, // R9
        '{4'h3, 1'b0, 4'hC, 8'h01, 1'b1, 5'h00, 1'b1, 1'b0, 8'h00, 1'b1}, // R9
        '{4'h9, 1'b1, 4'h6, 8'h80, 1'b1, 5'h03, 1'b1, 1'b0, 8'h00, 1'b0}  // R10
    };

    function automatic logic [31:0] mk(input logic arr, input logic [3:0] sel,
                                       input logic [7:0] off);
        return {9'h1FF, arr, sel, 10'h000, off};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle at a falling edge; claim checked at once, responses one clock later
    task automatic one_cycle(input string req, input logic arr, input logic [3:0] sel,
                             input logic [7:0] off, input logic wr, input logic e_claim,
                             input logic e_rv, input logic [7:0] e_data, input logic e_wa);
        cyc_valid = 1'b1; cyc_write = wr; cyc_addr = mk(arr, sel, off);
        #1;
        chk({req, " claim"}, {7'd0, claim}, {7'd0, e_claim});
        @(negedge clk);
        chk({req, " rd_valid"}, {7'd0, rd_valid}, {7'd0, e_rv});
        chk({req, " wr_accept"}, {7'd0, wr_accept}, {7'd0, e_wa});
        if (e_rv) chk({req, " rd_data"}, rd_data, e_data);
        cyc_valid = 1'b0; cyc_write = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state: R3 R9 outputs quiet
        chk("R3 reset rd_valid", {7'd0, rd_valid}, 8'd0);
        chk("R9 reset wr_accept", {7'd0, wr_accept}, 8'd0);
        chk("R1 reset claim", {7'd0, claim}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            strap_id = TBL[i].strap;
            gpi_pins = TBL[i].gpi;
            repeat (3) @(negedge clk);
            one_cycle($sformatf("R1/R3 vec%0d", i), TBL[i].arr, TBL[i].sel, TBL[i].off,
                      TBL[i].wr, TBL[i].e_claim, TBL[i].e_rv, TBL[i].e_data, TBL[i].e_wa);
        end

        // R1: valid low never claims even on matching field
        strap_id = 4'h0; cyc_valid = 1'b0; cyc_addr = mk(1'b0, 4'hF, 8'h00);
        #1 chk("R1 no valid", {7'd0, claim}, 8'd0);
        @(negedge clk);

        // R4: GPI latency with back-to-back reads
        gpi_pins = 5'h00; repeat (3) @(negedge clk);
        gpi_pins = 5'h1F;
        cyc_valid = 1'b1; cyc_write = 1'b0; cyc_addr = mk(1'b0, 4'hF, 8'h80);
        @(negedge clk); chk("R4 lat1", rd_data, 8'h00);
        @(negedge clk); chk("R4 lat2", rd_data, 8'h00);
        @(negedge clk); chk("R4 lat3", rd_data, 8'h1F);
        cyc_valid = 1'b0;
        @(negedge clk);
        chk("R3 single pulse", {7'd0, rd_valid}, 8'd0);

        // R7 R8: status reads while busy
        wr_busy = 1'b1; poll_bit7 = 1'b1;
        one_cycle("R7 R8 poll1", 1'b0, 4'hF, 8'h80, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
        one_cycle("R8 poll2", 1'b0, 4'hF, 8'h00, 1'b0, 1'b1, 1'b1, 8'h40, 1'b0);
        poll_bit7 = 1'b0;
        one_cycle("R7 poll3", 1'b0, 4'hF, 8'h01, 1'b0, 1'b1, 1'b1, 8'h80, 1'b0);
        one_cycle("R9 busy write", 1'b0, 4'hF, 8'h80, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        one_cycle("R8 after write", 1'b0, 4'hF, 8'h80, 1'b0, 1'b1, 1'b1, 8'hC0, 1'b0);
        wr_busy = 1'b0;
        one_cycle("R5 not busy", 1'b0, 4'hF, 8'h00, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0);
        wr_busy = 1'b1;
        one_cycle("R8 hold", 1'b0, 4'hF, 8'h00, 1'b0, 1'b1, 1'b1, 8'h80, 1'b0);
        one_cycle("R2 busy mismatch", 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        one_cycle("R8 mismatch no flip", 1'b0, 4'hF, 8'h00, 1'b0, 1'b1, 1'b1, 8'hC0, 1'b0);

        // R8: reset returns toggle to 0
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        one_cycle("R8 reset toggle", 1'b0, 4'hF, 8'h00, 1'b0, 1'b1, 1'b1, 8'h80, 1'b0);
        wr_busy = 1'b0;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule